// File: doc/BRIEF.md
# Configurable-Frame Double-Buffered UART

This block is a full-duplex asynchronous serial port. A transmitter turns bytes into framed serial bits on an output line, and a receiver turns frames on an input line back into bytes. The frame shape is set at runtime through plain configuration pins. The word length is five to eight bits, the stop field is one or two bits, and the parity is none, even or odd. The same shape applies to both directions. The bit rate comes from a shared divisor that produces a 16x oversampling tick.

Each direction has a one-byte holding register in front of its shift register. The host can queue the next byte while the current byte is still on the line. The receiver keeps a finished byte while the next frame is already arriving.

Host data moves through valid/ready streams. On the transmit side, `tx_ready` is high exactly when the holding register is empty. A byte is taken on any clock edge where `tx_valid` and `tx_ready` are both high. The host keeps `tx_valid` and `tx_data` steady until that edge.

On the receive side, `rx_valid` stays high and `rx_data` stays steady until the host raises `rx_ready`. The receiver cannot be stalled, because the line does not wait. A frame that completes while the holding register is still full is dropped, and the drop is reported on `rx_overrun`. Configuration should only change while both directions are idle.

Top module: `uart_dbuf`

## Requirements
- R1: The line idles high. A frame is a low start bit, then the data bits least significant first, then the parity bit if parity is on, then the stop bits, which are high.
- R2: `cfg_len` selects the word length: code 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Transmit data bits above the word length are not sent, and received bytes carry zeros above the word length.
- R3: With `cfg_stop2`=0 a frame has one stop bit; with `cfg_stop2`=1 it has two. The next queued frame starts on the cycle right after the last stop bit ends.
- R4: `cfg_par` selects parity: code 1 is even (data ones plus parity bit give an even count), 2 is odd, and 0 or 3 is none.
- R5: Transmit holding: `tx_ready` is high when the holding register is empty. It rises in the cycle the held byte moves into the shift register, which is the cycle after acceptance when the shifter is idle, or the cycle the last stop bit ends when the shifter is busy.
- R6: Each bit lasts 16 ticks, and a tick occurs every `baud_div`+1 clock cycles. The receiver samples each bit at its middle.
- R7: A start bit that is no longer low at its middle is treated as noise. It yields no byte.
- R8: `rx_ferr` is set with a byte whose first stop bit was sampled low. `rx_perr` is set with a byte whose parity bit does not match. Both flags travel with that byte and clear when the byte is taken. The byte is still delivered.
- R9: A received byte stays on `rx_data` with `rx_valid` high until taken. A frame that completes while the holding register is full and not being taken in that same cycle is discarded, and `rx_overrun` pulses for one cycle. A take in the completion cycle makes room, and the new byte is kept.
- R10: Transmit and receive run at the same time without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_len | input | 2 | Word length code (5 + code bits) |
| cfg_stop2 | input | 1 | Two stop bits when high |
| cfg_par | input | 2 | Parity code: 0 none, 1 even, 2 odd, 3 none |
| baud_div | input | DIV_W | Tick every baud_div+1 cycles |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmit holding register empty |
| tx_o | output | 1 | Serial output line |
| rx_i | input | 1 | Serial input line |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte waiting |
| rx_ready | input | 1 | Host takes the received byte |
| rx_ferr | output | 1 | Framing error for the waiting byte |
| rx_perr | output | 1 | Parity error for the waiting byte |
| rx_overrun | output | 1 | One-cycle pulse: a completed byte was discarded |

## Verification
The receiver can finish a frame in the same cycle the host takes the byte already held. That cycle decides whether the new byte is kept or counted as an overrun. The bench drives the input line itself, so it can compute the completion cycle from the frame length. It then sweeps the take pulse from two cycles before that cycle to two cycles after, and expects the new byte for each early or coincident take and an overrun for each late one.

On the transmit side, the end of the last stop bit coincides with the hand-over from the holding register. This is judged by the cycle `tx_ready` rises and by a start bit that follows with no gap, with one and with two stop bits.

// File: rtl/uart_dbuf_pkg.sv
package uart_dbuf_pkg;
  localparam int MAXD = 8;   // widest word
  localparam int FRW  = 12;  // start + 8 data + parity + 2 stop

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2,
    PAR_OFF  = 2'd3
  } par_e;

  typedef struct packed {
    logic [1:0] len;
    logic       stop2;
    par_e       par;
  } frame_cfg_t;

  function automatic logic [MAXD-1:0] len_mask(logic [1:0] len);
    return 8'hFF >> (2'd3 - len);
  endfunction

  function automatic logic has_par(par_e p);
    return (p == PAR_EVEN) || (p == PAR_ODD);
  endfunction

  function automatic logic par_of(logic [MAXD-1:0] d, logic [1:0] len, par_e p);
    return (^(d & len_mask(len))) ^ (p == PAR_ODD);
  endfunction
endpackage

// File: rtl/uart_dbuf_tick.sv
module uart_dbuf_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = (cnt_q == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/uart_dbuf_tx.sv
module uart_dbuf_tx
  import uart_dbuf_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  frame_cfg_t      cfg,
  input  logic [MAXD-1:0] tx_data,
  input  logic            tx_valid,
  output logic            tx_ready,
  output logic            tx_o
);
  localparam int CW = $clog2(OSR);

  logic [MAXD-1:0] hold_q;
  logic            hold_v;
  logic [FRW-1:0]  sh_q;
  logic            busy_q, txo_q;
  logic [CW-1:0]   os_q;
  logic [3:0]      left_q;
  logic [FRW-1:0]  fr;
  logic [3:0]      flen;
  logic            bit_end, last_end, load;

  assign tx_ready = !hold_v;
  assign tx_o     = txo_q;
  assign bit_end  = busy_q && tick && (os_q == CW'(OSR - 1));
  assign last_end = bit_end && (left_q == 4'd1);
  assign load     = hold_v && (!busy_q || last_end);

  always_comb begin
    int n;
    n = 5 + int'(cfg.len);
    fr = '1;
    fr[0] = 1'b0;
    for (int i = 0; i < MAXD; i++)
      if (i < n) fr[1+i] = hold_q[i];
    if (has_par(cfg.par)) fr[1+n] = par_of(hold_q, cfg.len, cfg.par);
    flen = 4'(2 + n + int'(has_par(cfg.par)) + int'(cfg.stop2));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      hold_v <= 1'b0;
      sh_q   <= '1;
      busy_q <= 1'b0;
      txo_q  <= 1'b1;
      os_q   <= '0;
      left_q <= '0;
    end else begin
      if (load) begin
        sh_q   <= fr;
        txo_q  <= fr[0];
        busy_q <= 1'b1;
        os_q   <= '0;
        left_q <= flen;
        hold_v <= 1'b0;
      end else if (bit_end) begin
        sh_q   <= {1'b1, sh_q[FRW-1:1]};
        txo_q  <= last_end ? 1'b1 : sh_q[1];
        left_q <= left_q - 4'd1;
        os_q   <= '0;
        if (last_end) busy_q <= 1'b0;
      end else if (busy_q && tick) begin
        os_q <= os_q + 1'b1;
      end
      if (tx_valid && !hold_v) begin
        hold_q <= tx_data;
        hold_v <= 1'b1;
      end
    end
  end

  // R1: an idle shifter leaves the line high
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> txo_q);
  // R5: room only reappears when the byte went into a now-busy shifter
  a_r5_room_on_move: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_ready) |-> busy_q);
endmodule

// File: rtl/uart_dbuf_rx.sv
module uart_dbuf_rx
  import uart_dbuf_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [1:0]      cfg_len,
  input  par_e            cfg_par,
  input  logic            rx_i,
  output logic [MAXD-1:0] rx_data,
  output logic            rx_valid,
  input  logic            rx_ready,
  output logic            rx_ferr,
  output logic            rx_perr,
  output logic            rx_overrun
);
  localparam int CW = $clog2(OSR);
  localparam int SW = MAXD + 2;

  typedef enum logic [1:0] {S_IDLE, S_START, S_BITS} rx_st_e;

  rx_st_e          st_q;
  logic            s1_q, s2_q;
  logic [CW-1:0]   os_q;
  logic [3:0]      cnt_q;
  logic [SW-1:0]   sh_q, sh_nx, aligned;
  logic [1:0]      len_q;
  par_e            par_q;
  logic [3:0]      n, m;
  logic [MAXD-1:0] word;
  logic            hp, done, bad_par, bad_stop;
  logic [MAXD-1:0] data_q;
  logic            valid_q, ferr_q, perr_q, ovr_q;

  assign hp       = has_par(par_q);
  assign n        = 4'd5 + {2'b00, len_q};
  assign m        = n + {3'b000, hp} + 4'd1;
  assign sh_nx    = {s2_q, sh_q[SW-1:1]};
  assign aligned  = sh_nx >> (4'd10 - m);
  assign word     = aligned[MAXD-1:0] & len_mask(len_q);
  assign bad_par  = hp && (aligned[n] != par_of(word, len_q, par_q));
  assign bad_stop = !aligned[m - 4'd1];
  assign done     = (st_q == S_BITS) && tick && (os_q == CW'(OSR - 1))
                    && (4'(cnt_q + 4'd1) == m);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b1;
      s2_q  <= 1'b1;
      st_q  <= S_IDLE;
      os_q  <= '0;
      cnt_q <= '0;
      sh_q  <= '0;
      len_q <= '0;
      par_q <= PAR_NONE;
    end else begin
      s1_q <= rx_i;
      s2_q <= s1_q;
      if (tick) begin
        unique case (st_q)
          S_IDLE: if (!s2_q) begin
            st_q  <= S_START;
            os_q  <= '0;
            len_q <= cfg_len;
            par_q <= cfg_par;
          end
          S_START: if (os_q == CW'(OSR/2 - 1)) begin
            st_q  <= s2_q ? S_IDLE : S_BITS;
            os_q  <= '0;
            cnt_q <= '0;
          end else os_q <= os_q + 1'b1;
          default: if (os_q == CW'(OSR - 1)) begin
            os_q  <= '0;
            sh_q  <= sh_nx;
            cnt_q <= cnt_q + 4'd1;
            if (done) st_q <= S_IDLE;
          end else os_q <= os_q + 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      ferr_q  <= 1'b0;
      perr_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      ovr_q <= 1'b0;
      if (done && valid_q && !rx_ready) begin
        ovr_q <= 1'b1;
      end else if (done) begin
        data_q  <= word;
        valid_q <= 1'b1;
        ferr_q  <= bad_stop;
        perr_q  <= bad_par;
      end else if (valid_q && rx_ready) begin
        valid_q <= 1'b0;
        ferr_q  <= 1'b0;
        perr_q  <= 1'b0;
      end
    end
  end

  assign rx_data    = data_q;
  assign rx_valid   = valid_q;
  assign rx_ferr    = ferr_q;
  assign rx_perr    = perr_q;
  assign rx_overrun = ovr_q;

  // R9: a waiting byte is held until the host takes it
  a_r9_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q && !rx_ready |=> valid_q && $stable(data_q));
  // R9: a drop only happens against a full holding register
  a_r9_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |-> valid_q);
  // R8: error flags only accompany a waiting byte
  a_r8_flags_with_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (ferr_q || perr_q) |-> valid_q);
endmodule

// File: rtl/uart_dbuf.sv
module uart_dbuf
  import uart_dbuf_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int OSR   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_len,
  input  logic             cfg_stop2,
  input  logic [1:0]       cfg_par,
  input  logic [DIV_W-1:0] baud_div,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic             tx_o,
  input  logic             rx_i,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic             rx_ferr,
  output logic             rx_perr,
  output logic             rx_overrun
);
  logic       tick;
  frame_cfg_t cfg;

  assign cfg.len   = cfg_len;
  assign cfg.stop2 = cfg_stop2;
  assign cfg.par   = par_e'(cfg_par);

  uart_dbuf_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div(baud_div), .tick(tick)
  );

  uart_dbuf_tx #(.OSR(OSR)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg(cfg),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_o(tx_o)
  );

  uart_dbuf_rx #(.OSR(OSR)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_len(cfg_len), .cfg_par(cfg.par),
    .rx_i(rx_i), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_ferr(rx_ferr), .rx_perr(rx_perr), .rx_overrun(rx_overrun)
  );
endmodule

// File: tb/sim_uart_dbuf.sv
`timescale 1ns/1ps
module sim_uart_dbuf;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0;
  logic [1:0] clen = 2'd3, cpar = 2'd0;
  logic       cstop = 1'b0;
  logic [7:0] baud = 8'd0;
  logic [7:0] tx_data = 8'd0;
  logic       tx_valid = 1'b0, rx_ready = 1'b0;
  logic       loop = 1'b1, rx_drv = 1'b1;
  logic       tx_ready, tx_o, rx_valid, rx_ferr, rx_perr, rx_overrun;
  logic [7:0] rx_data;
  logic       rx_line;

  assign rx_line = loop ? tx_o : rx_drv;

  uart_dbuf u0 (
    .clk(clk), .rst_n(rst_n), .cfg_len(clen), .cfg_stop2(cstop), .cfg_par(cpar),
    .baud_div(baud), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_o(tx_o), .rx_i(rx_line), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_ferr(rx_ferr), .rx_perr(rx_perr), .rx_overrun(rx_overrun)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int nb();
    return 5 + int'(clen);
  endfunction
  function automatic int hp();
    return (cpar == 2'd1 || cpar == 2'd2) ? 1 : 0;
  endfunction
  function automatic int flen();
    return 2 + nb() + hp() + int'(cstop);
  endfunction
  function automatic logic [7:0] msk();
    return 8'hFF >> (3 - int'(clen));
  endfunction
  function automatic logic [11:0] mkframe(logic [7:0] v);
    logic [11:0] f;
    int ones;
    f = '1;
    f[0] = 1'b0;
    ones = 0;
    for (int i = 0; i < nb(); i++) begin
      f[1+i] = v[i];
      ones += int'(v[i]);
    end
    if (hp() == 1) f[1+nb()] = ((ones % 2) == 1) ^ (cpar == 2'd2);
    return f;
  endfunction

  task automatic drive_rx(logic [7:0] v, bit badpar, bit badstop);
    logic [11:0] f;
    f = mkframe(v);
    if (badpar) f[1+nb()] = ~f[1+nb()];
    if (badstop) f[1+nb()+hp()] = 1'b0;
    for (int k = 0; k < flen(); k++) begin
      rx_drv = f[k];
      repeat (16) @(negedge clk);
    end
    rx_drv = 1'b1;
  endtask

  task automatic take_rx(output logic [7:0] d, output bit fe, output bit pe, output bit got);
    got = 0; d = 0; fe = 0; pe = 0;
    for (int t = 0; t < 1000 && !got; t++) begin
      @(negedge clk);
      if (rx_valid) begin
        got = 1; d = rx_data; fe = rx_ferr; pe = rx_perr;
        rx_ready = 1'b1;
        @(negedge clk);
        rx_ready = 1'b0;
      end
    end
  endtask

  task automatic send_loop(logic [7:0] v);
    logic [11:0] f;
    logic [7:0] d;
    bit fe, pe, got;
    int e, s, per, bad;
    repeat (40) @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_data = v; tx_valid = 1'b1; e = cyc;
    @(negedge clk);
    tx_valid = 1'b0;
    s = e + 2; per = 16 * (int'(baud) + 1); bad = 0;
    f = mkframe(v);
    for (int k = 0; k < flen(); k++) begin
      while (cyc < s + per * k + per / 2) @(negedge clk);
      if (tx_o !== f[k]) bad++;
    end
    chk(bad == 0, "R1", "tx bit mismatches", bad, 0);
    take_rx(d, fe, pe, got);
    chk(got && d == (v & msk()), "R2", "loopback byte", d, v & msk());
    chk(!fe && !pe, "R4", "clean frame flags", {fe, pe}, 0);
  endtask

  task automatic dbuf_test(bit two_stop);
    logic [7:0] d;
    bit fe, pe, got;
    int e, s, l;
    cstop = two_stop; clen = 2'd3; cpar = 2'd0; loop = 1'b1;
    repeat (60) @(negedge clk);
    tx_data = 8'h5A; tx_valid = 1'b1; e = cyc;
    @(negedge clk);
    @(negedge clk);
    chk(tx_ready == 1'b1, "R5", "ready after move", tx_ready, 1);
    tx_data = 8'hC3;
    @(negedge clk);
    tx_valid = 1'b0;
    s = e + 2; l = flen();
    while (cyc < s + 16 * l - 1) @(negedge clk);
    chk(tx_ready == 1'b0, "R5", "ready before last stop ends", tx_ready, 0);
    @(negedge clk);
    chk(tx_ready == 1'b1, "R3", "ready when next frame loads", tx_ready, 1);
    while (cyc < s + 16 * l + 8) @(negedge clk);
    chk(tx_o == 1'b0, "R3", "gapless next start bit", tx_o, 0);
    take_rx(d, fe, pe, got);
    chk(got && d == 8'h5A, "R10", "first duplex byte", d, 8'h5A);
    take_rx(d, fe, pe, got);
    chk(got && d == 8'hC3, "R10", "second duplex byte", d, 8'hC3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=0", 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    bit fe, pe, got;
    logic [7:0] vals [4];
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_o == 1 && tx_ready == 1 && rx_valid == 0 && rx_overrun == 0,
        "R1", "reset state", {tx_o, tx_ready, rx_valid, rx_overrun}, 4'b1100);

    // sweep every length, parity and stop setting in loopback
    for (int l = 0; l < 4; l++)
      for (int p = 0; p < 3; p++)
        for (int s = 0; s < 2; s++) begin
          clen = 2'(l); cpar = 2'(p); cstop = s[0];
          vals[0] = 8'h00; vals[1] = 8'hFF; vals[2] = 8'hA5; vals[3] = 8'(8'h3C + l * 7 + p * 3 + s);
          for (int i = 0; i < 4; i++) send_loop(vals[i]);
        end
    // R4: code 3 behaves as no parity
    clen = 2'd1; cpar = 2'd3; cstop = 1'b0;
    send_loop(8'h2B);

    // R6: slower tick, 32 cycles per bit
    baud = 8'd1; clen = 2'd2; cpar = 2'd1; cstop = 1'b1;
    send_loop(8'h6D);
    send_loop(8'h12);
    baud = 8'd0;

    // R5 / R3 / R10: double buffering with both stop settings
    dbuf_test(1'b0);
    dbuf_test(1'b1);

    // R7: short low pulse is rejected, receiver still works afterwards
    loop = 1'b0; clen = 2'd3; cpar = 2'd0; cstop = 1'b0;
    repeat (40) @(negedge clk);
    rx_drv = 1'b0;
    repeat (4) @(negedge clk);
    rx_drv = 1'b1;
    repeat (300) @(negedge clk);
    chk(rx_valid == 1'b0, "R7", "noise start yields no byte", rx_valid, 0);
    drive_rx(8'h96, 0, 0);
    take_rx(d, fe, pe, got);
    chk(got && d == 8'h96, "R7", "byte after noise", d, 8'h96);

    // R8: parity and framing errors
    clen = 2'd2; cpar = 2'd1;
    drive_rx(8'h35, 1, 0);
    take_rx(d, fe, pe, got);
    chk(got && d == 8'h35 && pe && !fe, "R8", "parity error flags", {d, fe, pe}, {8'h35, 2'b01});
    cpar = 2'd2;
    drive_rx(8'h4A, 0, 1);
    take_rx(d, fe, pe, got);
    chk(got && d == 8'h4A && fe && !pe, "R8", "framing error flags", {d, fe, pe}, {8'h4A, 2'b10});
    @(negedge clk);
    chk(!rx_ferr && !rx_perr, "R8", "flags cleared on take", {rx_ferr, rx_perr}, 0);

    // R9: take pulse swept around the completion cycle of a second frame
    clen = 2'd3; cpar = 2'd0; cstop = 1'b0;
    for (int off = -2; off <= 2; off++) begin
      int e2, dd;
      logic [7:0] sd;
      bit sv, so;
      repeat (30) @(negedge clk);
      drive_rx(8'h11, 0, 0);
      repeat (4) @(negedge clk);
      e2 = cyc; dd = e2 + 11 + 16 * 9;
      fork
        drive_rx(8'h22, 0, 0);
        begin
          while (cyc < dd + off - 1) @(negedge clk);
          rx_ready = 1'b1;
          @(negedge clk);
          rx_ready = 1'b0;
        end
        begin
          while (cyc < dd) @(negedge clk);
          sd = rx_data; sv = rx_valid; so = rx_overrun;
        end
      join
      if (off <= 0)
        chk(sv && !so && sd == 8'h22, "R9", $sformatf("take at offset %0d keeps new", off),
            {so, sd}, {1'b0, 8'h22});
      else
        chk(sv && so && sd == 8'h11, "R9", $sformatf("take at offset %0d drops new", off),
            {so, sd}, {1'b1, 8'h11});
      repeat (20) begin
        @(negedge clk);
        if (rx_valid) begin
          rx_ready = 1'b1;
          @(negedge clk);
          rx_ready = 1'b0;
        end
      end
      chk(!rx_valid && !rx_overrun, "R9", "drained", {rx_valid, rx_overrun}, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule